// File: doc/BRIEF.md
# Width-Limited In-Order Retire Unit

This block looks at the oldest entries of a reorder buffer once per cycle and decides which of them leave it. It walks the head window from the oldest entry forward. Entries that were squashed are dropped for free. Ordinary finished instructions are committed, up to a fixed number per cycle. The walk ends at the first entry that cannot go. Instructions that must not run speculatively are not committed at all. Serializing operations, barriers and loads that were held back are turned into a single request that travels backward to the execution side, asking for the operation to run now. A faulting instruction raises a trap request, but only once it is the oldest live work and the store buffer has drained.

Each committed instruction with a destination produces one write lane for the committed register map. Lanes are packed in program order. Every decision is a combinational function of the head window as it stands at the start of the cycle. The reorder buffer removes the retired entries at the clock edge, before any entry written in the same cycle becomes visible, so retirement and insertion never overlap. Registered state holds the youngest committed sequence number and the committed program counter pair. It also holds four event counters: committed instructions, dropped squashed entries, serializing stalls, and cycles that used the full width.

Top module: `retire_unit`

## Requirements
- R1: At most WIDTH non-squashed entries are committed per cycle. `retire_mask` is always a contiguous run starting at slot 0 (slot 0 is the oldest). The walk stops at the first slot that is invalid, has `hd_can_commit` low, or cannot commit for a reason given below.
- R2: A valid entry with `hd_squashed` set is retired at once, even after WIDTH commits in the same cycle. It does not use a commit lane. It adds one to `cnt_squashed`.
- R3: A valid, committable, unexecuted entry with `hd_nonspec` or `hd_barrier` set never retires. It raises `nspec_req` with its sequence number, `nspec_uncached` low, its `clr_can_commit` bit set, and `cnt_nspec_stall` incremented, but only when no entry committed before it this cycle and `stores_pending` is low. Otherwise it simply stalls.
- R4: A valid, committable, unexecuted load (`hd_load`, with neither serializing flag set) never retires. It raises `nspec_req` with `nspec_uncached` high and sets its `clr_can_commit` bit, whatever `stores_pending` is and however many entries committed before it.
- R5: A valid, committable entry with `hd_fault` set never retires. It raises `trap_req` with `trap_seq` equal to its sequence number only when no entry committed before it this cycle and `stores_pending` is low.
- R6: The k-th entry committed in a cycle drives map lane k. `map_wr_en[k]` equals its `hd_dst_valid`, and the lane carries its architectural and physical register numbers. After the edge, `done_seq` holds the sequence number of the youngest committed entry. It is unchanged in a cycle with no commit.
- R7: An executed store (`hd_store`) commits only if `hd_completed` is set, and otherwise stalls. Every committed non-store sets its `mark_done` bit. A committed store does not set it.
- R8: After a cycle with commits, `commit_pc` equals the youngest committed entry's `hd_next_pc`, and `commit_npc` equals that value plus 4.
- R9: `cnt_committed` grows by the number of committed entries. `cnt_full_width` grows by one in each cycle that committed exactly WIDTH entries.
- R10: While `rst` is high on a clock edge, `done_seq` and all counters clear to 0, `commit_pc` loads RESET_PC and `commit_npc` loads RESET_PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stores_pending | input | 1 | Store buffer still holds data to write back |
| hd_valid | input | WIN | Slot holds an entry (slot 0 oldest) |
| hd_squashed | input | WIN | Entry was squashed |
| hd_can_commit | input | WIN | Entry is ready to be examined |
| hd_executed | input | WIN | Entry finished execution |
| hd_nonspec | input | WIN | Entry must run non-speculatively (also store-conditional) |
| hd_barrier | input | WIN | Entry is a memory or write barrier |
| hd_load | input | WIN | Entry is a load |
| hd_fault | input | WIN | Entry carries a fault |
| hd_store | input | WIN | Entry is a store |
| hd_completed | input | WIN | Store has completed |
| hd_seq | input | WIN x SEQ_W | Sequence number per slot |
| hd_next_pc | input | WIN x PC_W | Next program counter per slot |
| hd_dst_valid | input | WIN | Entry writes a destination register |
| hd_dst_arch | input | WIN x AREG_W | Architectural destination |
| hd_dst_phys | input | WIN x PREG_W | Physical destination |
| retire_mask | output | WIN | Slots removed from the buffer this cycle |
| mark_done | output | WIN | Committed non-store slots to mark completed |
| clr_can_commit | output | WIN | Slot whose ready flag must be cleared |
| map_wr_en | output | WIDTH | Committed-map write enable per lane |
| map_wr_arch | output | WIDTH x AREG_W | Lane architectural register |
| map_wr_phys | output | WIDTH x PREG_W | Lane physical register |
| nspec_req | output | 1 | Backward request to execute the head non-speculatively |
| nspec_seq | output | SEQ_W | Sequence number of that request |
| nspec_uncached | output | 1 | Request is for a held-back load |
| trap_req | output | 1 | Fault at the head is ready to trap |
| trap_seq | output | SEQ_W | Sequence number of the faulting entry |
| done_seq | output | SEQ_W | Youngest committed sequence number |
| commit_pc | output | PC_W | Committed program counter |
| commit_npc | output | PC_W | Committed next program counter |
| cnt_committed | output | CNT_W | Committed instruction count |
| cnt_squashed | output | CNT_W | Dropped squashed entry count |
| cnt_nspec_stall | output | CNT_W | Serializing request count |
| cnt_full_width | output | CNT_W | Cycles that used the full width |

## Verification
Windows made entirely of ready entries show the width cap. Windows with a not-ready entry early on show that the walk stops there. Squashed entries placed both between commits and after the width limit tell apart "dropped for free" from "counted against width". Each special kind is placed at the head and also behind a committed entry, each with stores pending and with them drained: serializing, barrier, held-back load and fault. This separates the first-in-cycle and drain conditions, which apply to all of them except the load. Completed and uncompleted stores show the store-completion gate and the missing completed mark on stores.

// File: rtl/retire_pkg.sv
package retire_pkg;

    localparam int SEQ_W      = 16;
    localparam int PC_W       = 32;
    localparam int AREG_W     = 5;
    localparam int PREG_W     = 7;
    localparam int CNT_W      = 16;
    localparam int INST_BYTES = 4;

    typedef struct packed {
        logic              valid;
        logic              squashed;
        logic              can_commit;
        logic              executed;
        logic              nonspec;
        logic              barrier;
        logic              load;
        logic              fault;
        logic              store;
        logic              completed;
        logic [SEQ_W-1:0]  seq;
        logic [PC_W-1:0]   next_pc;
        logic              dst_valid;
        logic [AREG_W-1:0] arch;
        logic [PREG_W-1:0] phys;
    } head_ent_t;

    typedef struct packed {
        logic              en;
        logic              dst_valid;
        logic [AREG_W-1:0] arch;
        logic [PREG_W-1:0] phys;
        logic [SEQ_W-1:0]  seq;
        logic [PC_W-1:0]   next_pc;
    } lane_t;

    typedef enum logic [2:0] {
        ACT_STOP,
        ACT_DROP,
        ACT_COMMIT,
        ACT_NSPEC,
        ACT_UNCACHED,
        ACT_TRAP
    } act_e;

    // Decide what happens to one slot, given whether any entry has
    // committed before it this cycle and whether the width is used up.
    function automatic act_e classify(head_ent_t e, logic first,
                                      logic drained, logic full);
        act_e a;
        if (!e.valid)
            a = ACT_STOP;
        else if (e.squashed)
            a = ACT_DROP;
        else if (full || !e.can_commit)
            a = ACT_STOP;
        else if (e.fault)
            a = (first && drained) ? ACT_TRAP : ACT_STOP;
        else if (!e.executed) begin
            if (e.nonspec || e.barrier)
                a = (first && drained) ? ACT_NSPEC : ACT_STOP;
            else if (e.load)
                a = ACT_UNCACHED;
            else
                a = ACT_STOP;
        end
        else if (e.store && !e.completed)
            a = ACT_STOP;
        else
            a = ACT_COMMIT;
        return a;
    endfunction

    function automatic logic [PC_W-1:0] advance_pc(logic [PC_W-1:0] pc);
        return pc + PC_W'(INST_BYTES);
    endfunction

endpackage

// File: rtl/retire_scan.sv
module retire_scan
    import retire_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int WIN   = 8,
    localparam int NC_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  head_ent_t        ent [WIN],
    input  logic             stores_pending,
    output logic [WIN-1:0]   retire_mask,
    output logic [WIN-1:0]   done_mask,
    output logic [WIN-1:0]   clr_mask,
    output logic [WIN-1:0]   sq_mask,
    output lane_t            lanes [WIDTH],
    output logic [NC_W-1:0]  ncommit,
    output logic             nspec_req,
    output logic [SEQ_W-1:0] nspec_seq,
    output logic             nspec_unc,
    output logic             trap_req,
    output logic [SEQ_W-1:0] trap_seq
);

    always_comb begin
        logic stop;
        int   nc;
        act_e act;
        retire_mask = '0;
        done_mask   = '0;
        clr_mask    = '0;
        sq_mask     = '0;
        nspec_req   = 1'b0;
        nspec_seq   = '0;
        nspec_unc   = 1'b0;
        trap_req    = 1'b0;
        trap_seq    = '0;
        for (int k = 0; k < WIDTH; k++) lanes[k] = '0;
        stop = 1'b0;
        nc   = 0;
        for (int i = 0; i < WIN; i++) begin
            if (!stop) begin
                act = classify(ent[i], nc == 0, !stores_pending, nc == WIDTH);
                case (act)
                    ACT_DROP: begin
                        retire_mask[i] = 1'b1;
                        sq_mask[i]     = 1'b1;
                    end
                    ACT_COMMIT: begin
                        retire_mask[i] = 1'b1;
                        done_mask[i]   = !ent[i].store;
                        for (int k = 0; k < WIDTH; k++) begin
                            if (k == nc) begin
                                lanes[k].en        = 1'b1;
                                lanes[k].dst_valid = ent[i].dst_valid;
                                lanes[k].arch      = ent[i].arch;
                                lanes[k].phys      = ent[i].phys;
                                lanes[k].seq       = ent[i].seq;
                                lanes[k].next_pc   = ent[i].next_pc;
                            end
                        end
                        nc = nc + 1;
                    end
                    ACT_NSPEC, ACT_UNCACHED: begin
                        nspec_req   = 1'b1;
                        nspec_seq   = ent[i].seq;
                        nspec_unc   = (act == ACT_UNCACHED);
                        clr_mask[i] = 1'b1;
                        stop        = 1'b1;
                    end
                    ACT_TRAP: begin
                        trap_req = 1'b1;
                        trap_seq = ent[i].seq;
                        stop     = 1'b1;
                    end
                    default: stop = 1'b1;
                endcase
            end
        end
        ncommit = NC_W'(nc);
    end

    // R1: retired slots always form a run from the oldest slot
    p_prefix_r1: assert property (@(posedge clk) disable iff (rst)
        (retire_mask & (retire_mask + WIN'(1))) == '0);

    // R3: at most one ready flag is cleared per cycle
    p_one_clear_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_mask));

    // R3: a serializing request only goes out once stores have drained
    p_nspec_drained_r3: assert property (@(posedge clk) disable iff (rst)
        (nspec_req && !nspec_unc) |-> (!stores_pending && ncommit == '0));

    // R5: a trap only goes out once stores have drained
    p_trap_drained_r5: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (!stores_pending && ncommit == '0 && !nspec_req));

endmodule

// File: rtl/retire_arch_state.sv
module retire_arch_state
    import retire_pkg::*;
#(
    parameter int              WIDTH    = 4,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_t            lanes [WIDTH],
    output logic [SEQ_W-1:0] done_seq,
    output logic [PC_W-1:0]  commit_pc,
    output logic [PC_W-1:0]  commit_npc
);

    logic  any_commit;
    lane_t youngest;

    always_comb begin
        any_commit = 1'b0;
        youngest   = '0;
        for (int k = 0; k < WIDTH; k++) begin
            if (lanes[k].en) begin
                any_commit = 1'b1;
                youngest   = lanes[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_seq   <= '0;
            commit_pc  <= RESET_PC;
            commit_npc <= advance_pc(RESET_PC);
        end else if (any_commit) begin
            done_seq   <= youngest.seq;
            commit_pc  <= youngest.next_pc;
            commit_npc <= advance_pc(youngest.next_pc);
        end
    end

    // R6: the completed sequence number only moves on a commit
    p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !lanes[0].en |=> $stable(done_seq));

    // R8: the next program counter trails by one instruction
    p_npc_step_r8: assert property (@(posedge clk) disable iff (rst)
        lanes[0].en |=> (commit_npc == commit_pc + PC_W'(INST_BYTES)));

endmodule

// File: rtl/retire_perf.sv
module retire_perf
    import retire_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int WIN   = 8,
    localparam int NC_W = $clog2(WIDTH + 1),
    localparam int NCNT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NC_W-1:0]  ncommit,
    input  logic [WIN-1:0]   sq_mask,
    input  logic             nspec_stall,
    output logic [CNT_W-1:0] cnt_committed,
    output logic [CNT_W-1:0] cnt_squashed,
    output logic [CNT_W-1:0] cnt_nspec_stall,
    output logic [CNT_W-1:0] cnt_full_width
);

    logic [CNT_W-1:0] inc [NCNT];
    logic [CNT_W-1:0] cnt [NCNT];

    assign inc[0] = CNT_W'(ncommit);
    assign inc[1] = CNT_W'($countones(sq_mask));
    assign inc[2] = CNT_W'(nspec_stall);
    assign inc[3] = CNT_W'(ncommit == NC_W'(WIDTH));

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) cnt[g] <= '0;
            else     cnt[g] <= cnt[g] + inc[g];
        end
    end

    assign cnt_committed   = cnt[0];
    assign cnt_squashed    = cnt[1];
    assign cnt_nspec_stall = cnt[2];
    assign cnt_full_width  = cnt[3];

    // R9: the full-width counter only moves when the width was used up
    p_full_only_r9: assert property (@(posedge clk) disable iff (rst)
        (ncommit != NC_W'(WIDTH)) |=> $stable(cnt_full_width));

    // R2: no squashed entries dropped, no change in that counter
    p_sq_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (sq_mask == '0) |=> $stable(cnt_squashed));

endmodule

// File: rtl/retire_unit.sv
module retire_unit
    import retire_pkg::*;
#(
    parameter int              WIDTH    = 4,
    parameter int              WIN      = 8,
    parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           stores_pending,
    input  logic [WIN-1:0]                 hd_valid,
    input  logic [WIN-1:0]                 hd_squashed,
    input  logic [WIN-1:0]                 hd_can_commit,
    input  logic [WIN-1:0]                 hd_executed,
    input  logic [WIN-1:0]                 hd_nonspec,
    input  logic [WIN-1:0]                 hd_barrier,
    input  logic [WIN-1:0]                 hd_load,
    input  logic [WIN-1:0]                 hd_fault,
    input  logic [WIN-1:0]                 hd_store,
    input  logic [WIN-1:0]                 hd_completed,
    input  logic [WIN-1:0][SEQ_W-1:0]      hd_seq,
    input  logic [WIN-1:0][PC_W-1:0]       hd_next_pc,
    input  logic [WIN-1:0]                 hd_dst_valid,
    input  logic [WIN-1:0][AREG_W-1:0]     hd_dst_arch,
    input  logic [WIN-1:0][PREG_W-1:0]     hd_dst_phys,
    output logic [WIN-1:0]                 retire_mask,
    output logic [WIN-1:0]                 mark_done,
    output logic [WIN-1:0]                 clr_can_commit,
    output logic [WIDTH-1:0]               map_wr_en,
    output logic [WIDTH-1:0][AREG_W-1:0]   map_wr_arch,
    output logic [WIDTH-1:0][PREG_W-1:0]   map_wr_phys,
    output logic                           nspec_req,
    output logic [SEQ_W-1:0]               nspec_seq,
    output logic                           nspec_uncached,
    output logic                           trap_req,
    output logic [SEQ_W-1:0]               trap_seq,
    output logic [SEQ_W-1:0]               done_seq,
    output logic [PC_W-1:0]                commit_pc,
    output logic [PC_W-1:0]                commit_npc,
    output logic [CNT_W-1:0]               cnt_committed,
    output logic [CNT_W-1:0]               cnt_squashed,
    output logic [CNT_W-1:0]               cnt_nspec_stall,
    output logic [CNT_W-1:0]               cnt_full_width
);

    localparam int NC_W = $clog2(WIDTH + 1);

    head_ent_t       ent [WIN];
    lane_t           lanes [WIDTH];
    logic [WIN-1:0]  sq_mask;
    logic [NC_W-1:0] ncommit;
    logic [WIDTH-1:0] lane_en;

    for (genvar s = 0; s < WIN; s++) begin : g_ent
        always_comb begin
            ent[s].valid      = hd_valid[s];
            ent[s].squashed   = hd_squashed[s];
            ent[s].can_commit = hd_can_commit[s];
            ent[s].executed   = hd_executed[s];
            ent[s].nonspec    = hd_nonspec[s];
            ent[s].barrier    = hd_barrier[s];
            ent[s].load       = hd_load[s];
            ent[s].fault      = hd_fault[s];
            ent[s].store      = hd_store[s];
            ent[s].completed  = hd_completed[s];
            ent[s].seq        = hd_seq[s];
            ent[s].next_pc    = hd_next_pc[s];
            ent[s].dst_valid  = hd_dst_valid[s];
            ent[s].arch       = hd_dst_arch[s];
            ent[s].phys       = hd_dst_phys[s];
        end
    end

    retire_scan #(.WIDTH(WIDTH), .WIN(WIN)) u_scan (
        .clk            (clk),
        .rst            (rst),
        .ent            (ent),
        .stores_pending (stores_pending),
        .retire_mask    (retire_mask),
        .done_mask      (mark_done),
        .clr_mask       (clr_can_commit),
        .sq_mask        (sq_mask),
        .lanes          (lanes),
        .ncommit        (ncommit),
        .nspec_req      (nspec_req),
        .nspec_seq      (nspec_seq),
        .nspec_unc      (nspec_uncached),
        .trap_req       (trap_req),
        .trap_seq       (trap_seq)
    );

    retire_arch_state #(.WIDTH(WIDTH), .RESET_PC(RESET_PC)) u_state (
        .clk        (clk),
        .rst        (rst),
        .lanes      (lanes),
        .done_seq   (done_seq),
        .commit_pc  (commit_pc),
        .commit_npc (commit_npc)
    );

    retire_perf #(.WIDTH(WIDTH), .WIN(WIN)) u_perf (
        .clk             (clk),
        .rst             (rst),
        .ncommit         (ncommit),
        .sq_mask         (sq_mask),
        .nspec_stall     (nspec_req && !nspec_uncached),
        .cnt_committed   (cnt_committed),
        .cnt_squashed    (cnt_squashed),
        .cnt_nspec_stall (cnt_nspec_stall),
        .cnt_full_width  (cnt_full_width)
    );

    for (genvar k = 0; k < WIDTH; k++) begin : g_lane
        assign lane_en[k]     = lanes[k].en;
        assign map_wr_en[k]   = lanes[k].en && lanes[k].dst_valid;
        assign map_wr_arch[k] = lanes[k].arch;
        assign map_wr_phys[k] = lanes[k].phys;
    end

    // R1: every used lane matches one retired, non-squashed slot
    p_lane_count_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(lane_en) == $countones(retire_mask & ~hd_squashed));

    // R7: only committed entries may be marked completed
    p_mark_sub_r7: assert property (@(posedge clk) disable iff (rst)
        (mark_done & ~retire_mask) == '0);

endmodule

// File: tb/retire_unit_tb.sv
module retire_unit_tb;
    import retire_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 4;
    localparam int WIN        = 8;
    localparam int NV         = 17;
    localparam logic [PC_W-1:0] RESET_PC = 32'h0000_1000;

    // slot kinds (slot 0 in the low nibble):
    // 0 empty, 1 ready with dest, 2 squashed, 3 not ready, 4 serializing,
    // 5 held load, 6 fault, 7 completed store, 8 uncompleted store, 9 barrier
    localparam logic [31:0] V_KIND [NV] = '{
        32'h11111111, 32'h11111311, 32'h11111122, 32'h11112121,
        32'h11111114, 32'h11111114, 32'h11111141, 32'h11111142,
        32'h11111151, 32'h11111116, 32'h11111116, 32'h11111161,
        32'h11111187, 32'h11111119, 32'h11111110, 32'h22222222,
        32'h11221111 };
    localparam logic       V_SP   [NV] = '{0,0,0,0, 0,1,0,0, 1,0,1,0, 0,0,0,0, 0};
    localparam logic [7:0] V_RET  [NV] = '{8'h0F,8'h03,8'h3F,8'h3F, 8'h00,8'h00,8'h01,8'h01,
                                           8'h01,8'h00,8'h00,8'h01, 8'h01,8'h00,8'h00,8'hFF, 8'h3F};
    localparam logic       V_NS   [NV] = '{0,0,0,0, 1,0,0,1, 1,0,0,0, 0,1,0,0, 0};
    localparam logic       V_UNC  [NV] = '{0,0,0,0, 0,0,0,0, 1,0,0,0, 0,0,0,0, 0};
    localparam logic       V_TRAP [NV] = '{0,0,0,0, 0,0,0,0, 0,1,0,0, 0,0,0,0, 0};
    localparam logic [7:0] V_CLR  [NV] = '{8'h00,8'h00,8'h00,8'h00, 8'h01,8'h00,8'h00,8'h02,
                                           8'h02,8'h00,8'h00,8'h00, 8'h00,8'h01,8'h00,8'h00, 8'h00};

    logic clk = 1'b0;
    logic rst;
    logic stores_pending;
    logic [WIN-1:0] hd_valid, hd_squashed, hd_can_commit, hd_executed, hd_nonspec;
    logic [WIN-1:0] hd_barrier, hd_load, hd_fault, hd_store, hd_completed, hd_dst_valid;
    logic [WIN-1:0][SEQ_W-1:0]  hd_seq;
    logic [WIN-1:0][PC_W-1:0]   hd_next_pc;
    logic [WIN-1:0][AREG_W-1:0] hd_dst_arch;
    logic [WIN-1:0][PREG_W-1:0] hd_dst_phys;
    logic [WIN-1:0] retire_mask, mark_done, clr_can_commit;
    logic [WIDTH-1:0] map_wr_en;
    logic [WIDTH-1:0][AREG_W-1:0] map_wr_arch;
    logic [WIDTH-1:0][PREG_W-1:0] map_wr_phys;
    logic nspec_req, nspec_uncached, trap_req;
    logic [SEQ_W-1:0] nspec_seq, trap_seq, done_seq;
    logic [PC_W-1:0] commit_pc, commit_npc;
    logic [CNT_W-1:0] cnt_committed, cnt_squashed, cnt_nspec_stall, cnt_full_width;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    retire_unit #(.WIDTH(WIDTH), .WIN(WIN), .RESET_PC(RESET_PC)) u_dut (.*);

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [SEQ_W-1:0] seq_of(int v, int s);
        return SEQ_W'(v * 16 + s + 1);
    endfunction

    function automatic logic [PC_W-1:0] npc_of(logic [SEQ_W-1:0] q);
        return 32'h0000_4000 + (PC_W'(q) << 3);
    endfunction

    task automatic clear_inputs();
        stores_pending = 1'b0;
        hd_valid = '0; hd_squashed = '0; hd_can_commit = '0; hd_executed = '0;
        hd_nonspec = '0; hd_barrier = '0; hd_load = '0; hd_fault = '0;
        hd_store = '0; hd_completed = '0; hd_dst_valid = '0;
        hd_seq = '0; hd_next_pc = '0; hd_dst_arch = '0; hd_dst_phys = '0;
    endtask

    task automatic drive(int v);
        clear_inputs();
        stores_pending = V_SP[v];
        for (int s = 0; s < WIN; s++) begin
            logic [3:0] k;
            logic [SEQ_W-1:0] q;
            k = V_KIND[v][4*s +: 4];
            q = seq_of(v, s);
            hd_seq[s]      = q;
            hd_next_pc[s]  = npc_of(q);
            hd_dst_arch[s] = q[4:0];
            hd_dst_phys[s] = q[6:0] ^ 7'h15;
            hd_valid[s]    = (k != 4'd0);
            hd_squashed[s] = (k == 4'd2);
            hd_can_commit[s] = !(k inside {4'd0, 4'd2, 4'd3});
            hd_executed[s] = (k inside {4'd1, 4'd6, 4'd7, 4'd8});
            hd_dst_valid[s] = (k == 4'd1);
            hd_nonspec[s]  = (k == 4'd4);
            hd_barrier[s]  = (k == 4'd9);
            hd_load[s]     = (k == 4'd5);
            hd_fault[s]    = (k == 4'd6);
            hd_store[s]    = (k inside {4'd7, 4'd8});
            hd_completed[s] = (k == 4'd7);
        end
    endtask

    logic [CNT_W-1:0] e_com, e_sq, e_ns, e_full;
    logic [SEQ_W-1:0] e_done;
    logic [PC_W-1:0]  e_pc;

    task automatic check_regs(string tag);
        check(done_seq == e_done, "R6", {tag, " done_seq"}, done_seq, e_done);
        check(commit_pc == e_pc, "R8", {tag, " commit_pc"}, commit_pc, e_pc);
        check(commit_npc == e_pc + 4, "R8", {tag, " commit_npc"}, commit_npc, e_pc + 4);
        check(cnt_committed == e_com, "R9", {tag, " committed"}, cnt_committed, e_com);
        check(cnt_full_width == e_full, "R9", {tag, " full"}, cnt_full_width, e_full);
        check(cnt_squashed == e_sq, "R2", {tag, " squashed"}, cnt_squashed, e_sq);
        check(cnt_nspec_stall == e_ns, "R3", {tag, " stalls"}, cnt_nspec_stall, e_ns);
    endtask

    task automatic reset_model();
        e_com = '0; e_sq = '0; e_ns = '0; e_full = '0; e_done = '0; e_pc = RESET_PC;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        clear_inputs();
        rst = 1'b1;
        reset_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check_regs("R10 reset");
        check(retire_mask == '0, "R10", "empty window retire", retire_mask, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            logic [WIN-1:0] sqm, cm, mk;
            logic [WIDTH-1:0] e_en;
            int nc;
            logic [SEQ_W-1:0] last;
            @(negedge clk);
            drive(v);
            #1;
            sqm = '0; cm = '0; mk = '0; e_en = '0; nc = 0; last = '0;
            for (int s = 0; s < WIN; s++) begin
                logic [3:0] k;
                k = V_KIND[v][4*s +: 4];
                if (V_RET[v][s]) begin
                    if (k == 4'd2) sqm[s] = 1'b1;
                    else begin
                        cm[s] = 1'b1;
                        if (k != 4'd7) mk[s] = 1'b1;
                        last = seq_of(v, s);
                        if (k == 4'd1) begin
                            e_en[nc] = 1'b1;
                            check(map_wr_arch[nc] == last[4:0], "R6", $sformatf("v%0d lane arch", v),
                                  map_wr_arch[nc], last[4:0]);
                            check(map_wr_phys[nc] == (last[6:0] ^ 7'h15), "R6",
                                  $sformatf("v%0d lane phys", v), map_wr_phys[nc], last[6:0] ^ 7'h15);
                        end
                        nc++;
                    end
                end
            end
            check(retire_mask == V_RET[v], "R1", $sformatf("v%0d retire", v), retire_mask, V_RET[v]);
            check(map_wr_en == e_en, "R6", $sformatf("v%0d lane en", v), map_wr_en, e_en);
            check(mark_done == mk, "R7", $sformatf("v%0d mark", v), mark_done, mk);
            check(clr_can_commit == V_CLR[v], "R3", $sformatf("v%0d clear", v), clr_can_commit, V_CLR[v]);
            check(nspec_req == V_NS[v], "R3", $sformatf("v%0d nspec", v), nspec_req, V_NS[v]);
            check(nspec_uncached == V_UNC[v], "R4", $sformatf("v%0d uncached", v), nspec_uncached, V_UNC[v]);
            if (V_NS[v]) begin
                logic [SEQ_W-1:0] qs;
                qs = '0;
                for (int s = 0; s < WIN; s++) if (V_CLR[v][s]) qs = seq_of(v, s);
                check(nspec_seq == qs, "R4", $sformatf("v%0d nspec seq", v), nspec_seq, qs);
            end
            check(trap_req == V_TRAP[v], "R5", $sformatf("v%0d trap", v), trap_req, V_TRAP[v]);
            if (V_TRAP[v])
                check(trap_seq == seq_of(v, 0), "R5", "trap seq", trap_seq, seq_of(v, 0));
            e_com += CNT_W'(nc);
            e_sq  += CNT_W'($countones(sqm));
            if (V_NS[v] && !V_UNC[v]) e_ns += 1;
            if (nc == WIDTH) e_full += 1;
            if (nc > 0) begin
                e_done = last;
                e_pc   = npc_of(last);
            end
            @(posedge clk);
            #1;
            check_regs($sformatf("v%0d", v));
        end

        // R10: reset in the middle of a run clears state again
        @(negedge clk);
        drive(0);
        rst = 1'b1;
        @(posedge clk);
        #1;
        reset_model();
        check_regs("R10 mid-run");
        @(negedge clk);
        rst = 1'b0;
        clear_inputs();
        @(posedge clk);
        #1;
        check_regs("R10 idle");
        finish_run();
    end

endmodule